// File: doc/BRIEF.md
# Lazy Transaction Conflict Detector

This block sits beside one processor's private cache in a snooping multiprocessor that runs hardware transactions. While a transaction is open, every load and store the core makes is noted, by cache line, in a read set or a write set. Nothing is checked against other processors at that point. Stores stay private until the transaction commits. When the core asks to commit, the block requests the shared bus. Once arbitration grants it, the block issues the buffered store lines one per cycle. The cache then turns each one into the coherence traffic its line state requires.

Conflicts are detected lazily. Only a commit broadcast seen from another processor is compared with the local sets. A line match in either set raises an abort for that cycle. Both sets are then emptied and the transaction reopens empty, so the core replays it from its first operation. After the block has won the bus and begun issuing, snooped broadcasts no longer abort it. If a set runs out of room, the transaction drops into a serialized, non-transactional mode, and a sticky flag records why. Two wrapping counters record how many aborts and how many commits have occurred.

Top module: `tmcd_tx_tracker`

## Requirements
- R1: After reset the block is idle: in_tx, bus_req, cmt_valid, commit_done, abort, serial_mode and ovf_flag are 0, and both counters are 0.
- R2: A tx_begin pulse while idle opens a transaction (in_tx=1) and clears ovf_flag; tx_begin is ignored in any other state. While open, an access is recorded by its line number acc_addr >> OFF_BITS (6 by default), a load into the read set and a store into the write set. A line already present in that set is not stored again.
- R3: While the transaction is open or waiting for the bus, a snoop_valid whose line number matches any read-set or write-set entry drives abort high in that same cycle, with any byte offset. Both sets are emptied, any access presented in that cycle is discarded, and the next cycle finds the transaction open with empty sets (in_tx=1, bus_req=0).
- R4: abort stays low for a snoop whose line matches no entry, and for any snoop while idle, in serial mode, or while write-set lines are being issued.
- R5: commit_req while open moves to the waiting state, where bus_req=1 until bus_grant is seen. An access presented in the same cycle as commit_req is still recorded. Accesses made while waiting are ignored.
- R6: The cycle after bus_grant, the write-set lines are issued on cmt_line with cmt_valid=1, one per cycle, in the order they were first recorded. commit_done is high together with the last line, or alone for one cycle if the write set is empty. The next cycle the block is idle with empty sets.
- R7: While open, an access to a new line when the target set already holds DEPTH (4) lines sets ovf_flag, empties both sets and enters serial mode (serial_mode=1, in_tx=0). commit_req in serial mode returns to idle. ovf_flag stays set until the next tx_begin.
- R8: abort_count rises by one for each abort. commit_count rises by one for each commit_done and for each serial-mode completion. Both wrap at STAT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| acc_valid | input | 1 | Core access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access byte address |
| commit_req | input | 1 | Core asks to commit (or finish serial mode) |
| bus_grant | input | 1 | Arbiter grants the bus for commit |
| snoop_valid | input | 1 | Another processor's commit broadcast |
| snoop_addr | input | ADDR_W | Broadcast byte address |
| in_tx | output | 1 | Transaction open, waiting or issuing |
| bus_req | output | 1 | Requesting the bus to commit |
| cmt_valid | output | 1 | A write-set line is being issued |
| cmt_line | output | ADDR_W-OFF_BITS | Line number being issued |
| commit_done | output | 1 | Final cycle of a commit |
| abort | output | 1 | Conflict abort this cycle |
| serial_mode | output | 1 | Serialized fallback after overflow |
| ovf_flag | output | 1 | Sticky set-overflow status |
| abort_count | output | STAT_W | Aborts seen |
| commit_count | output | STAT_W | Commits completed |

## Verification
Snoops are aimed at a line in the read set, at a line in the write set, at an unrecorded line, and at a recorded line with a different byte offset. Together these separate line-granular matching from address matching and show that both sets are probed. The same snoops are repeated while waiting for the bus, while issuing and in serial mode, which shows which states are exposed to abort. Duplicate lines filling a set, followed by one new line, locate the exact overflow point. A long random phase over eight lines, compared cycle by cycle with a queue-based model, checks issue order, the clearing that follows an abort, and the counters.

// File: rtl/tmcd_pkg.sv
package tmcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_WAIT,
    ST_ISSUE,
    ST_SERIAL
  } tx_state_e;

  localparam int unsigned BANK_RD = 0;
  localparam int unsigned BANK_WR = 1;
endpackage

// File: rtl/tmcd_set_pair.sv
module tmcd_set_pair #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LINE_W = 10,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ins_en,
  input  logic              ins_bank,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit,
  output logic              ins_present,
  output logic              ins_full,
  output logic [CW-1:0]     wr_count,
  input  logic [IW-1:0]     rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] lines [2][DEPTH];
  logic [DEPTH-1:0]  vld   [2];
  logic [CW-1:0]     cnt   [2];
  logic [1:0]        probe_b, present_b, full_b, ins_ok;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DEPTH-1:0] pm, im;
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      assign pm[e] = vld[b][e] && (lines[b][e] == probe_line);
      assign im[e] = vld[b][e] && (lines[b][e] == ins_line);
    end
    assign probe_b[b]   = |pm;
    assign present_b[b] = |im;
    assign full_b[b]    = (cnt[b] == CW'(DEPTH));
    assign ins_ok[b]    = ins_en && (ins_bank == b[0]) && !present_b[b] && !full_b[b];

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        vld[b] <= '0;
        cnt[b] <= '0;
      end else if (ins_ok[b]) begin
        vld[b] <= vld[b] | (DEPTH'(1) << cnt[b]);
        cnt[b] <= cnt[b] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ins_ok[b] && cnt[b] == CW'(e)) lines[b][e] <= ins_line;
      end
    end
  end

  assign probe_hit   = |probe_b;
  assign ins_present = present_b[ins_bank];
  assign ins_full    = full_b[ins_bank];
  assign wr_count    = cnt[tmcd_pkg::BANK_WR];
  assign rd_line     = lines[tmcd_pkg::BANK_WR][rd_idx];
endmodule

// File: rtl/tmcd_ctrl.sv
module tmcd_ctrl #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned STAT_W = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              acc_valid,
  input  logic              commit_req,
  input  logic              bus_grant,
  input  logic              snoop_valid,
  input  logic              snoop_hit,
  input  logic              acc_present,
  input  logic              acc_full,
  input  logic [CW-1:0]     wr_count,
  output logic              set_clear,
  output logic              set_ins,
  output logic              ovf_evt,
  output logic              abort,
  output logic              cmt_valid,
  output logic [IW-1:0]     cmt_idx,
  output logic              commit_done,
  output logic              in_tx,
  output logic              bus_req,
  output logic              serial_mode,
  output logic              ovf_flag,
  output logic [STAT_W-1:0] abort_count,
  output logic [STAT_W-1:0] commit_count
);
  import tmcd_pkg::*;

  tx_state_e st, st_nx;
  logic      serial_done;

  function automatic logic issue_last(input logic [CW-1:0] n, input logic [IW-1:0] i);
    return (n == '0) || ((CW'(i) + 1'b1) == n);
  endfunction

  assign abort       = (st == ST_OPEN || st == ST_WAIT) && snoop_valid && snoop_hit;
  assign ovf_evt     = (st == ST_OPEN) && acc_valid && !abort && !acc_present && acc_full;
  assign set_ins     = (st == ST_OPEN) && acc_valid && !abort && !ovf_evt;
  assign cmt_valid   = (st == ST_ISSUE) && (wr_count != '0);
  assign commit_done = (st == ST_ISSUE) && issue_last(wr_count, cmt_idx);
  assign serial_done = (st == ST_SERIAL) && commit_req;
  assign set_clear   = abort || ovf_evt || commit_done;
  assign in_tx       = (st == ST_OPEN) || (st == ST_WAIT) || (st == ST_ISSUE);
  assign bus_req     = (st == ST_WAIT);
  assign serial_mode = (st == ST_SERIAL);

  always_comb begin
    st_nx = st;
    if (abort) begin
      st_nx = ST_OPEN;
    end else begin
      unique case (st)
        ST_IDLE:   if (tx_begin) st_nx = ST_OPEN;
        ST_OPEN:   if (ovf_evt) st_nx = ST_SERIAL;
                   else if (commit_req) st_nx = ST_WAIT;
        ST_WAIT:   if (bus_grant) st_nx = ST_ISSUE;
        ST_ISSUE:  if (commit_done) st_nx = ST_IDLE;
        ST_SERIAL: if (commit_req) st_nx = ST_IDLE;
        default:   st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cmt_idx      <= '0;
      ovf_flag     <= 1'b0;
      abort_count  <= '0;
      commit_count <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_WAIT) cmt_idx <= '0;
      else if (st == ST_ISSUE && !commit_done) cmt_idx <= cmt_idx + 1'b1;
      if (ovf_evt) ovf_flag <= 1'b1;
      else if (st == ST_IDLE && tx_begin) ovf_flag <= 1'b0;
      if (abort) abort_count <= abort_count + 1'b1;
      if (commit_done || serial_done) commit_count <= commit_count + 1'b1;
    end
  end
endmodule

// File: rtl/tmcd_tx_tracker.sv
module tmcd_tx_tracker #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned OFF_BITS = 6,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned STAT_W   = 16,
  localparam int unsigned LINE_W = ADDR_W - OFF_BITS,
  localparam int unsigned CW     = $clog2(DEPTH + 1),
  localparam int unsigned IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              commit_req,
  input  logic              bus_grant,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              in_tx,
  output logic              bus_req,
  output logic              cmt_valid,
  output logic [LINE_W-1:0] cmt_line,
  output logic              commit_done,
  output logic              abort,
  output logic              serial_mode,
  output logic              ovf_flag,
  output logic [STAT_W-1:0] abort_count,
  output logic [STAT_W-1:0] commit_count
);
  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return LINE_W'(a >> OFF_BITS);
  endfunction

  logic          set_clear, set_ins, ovf_evt;
  logic          snoop_hit, acc_present, acc_full;
  logic [CW-1:0] wr_count;
  logic [IW-1:0] cmt_idx;

  tmcd_set_pair #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_sets (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (set_clear),
    .ins_en     (set_ins),
    .ins_bank   (acc_write),
    .ins_line   (line_of(acc_addr)),
    .probe_line (line_of(snoop_addr)),
    .probe_hit  (snoop_hit),
    .ins_present(acc_present),
    .ins_full   (acc_full),
    .wr_count   (wr_count),
    .rd_idx     (cmt_idx),
    .rd_line    (cmt_line)
  );

  tmcd_ctrl #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_begin    (tx_begin),
    .acc_valid   (acc_valid),
    .commit_req  (commit_req),
    .bus_grant   (bus_grant),
    .snoop_valid (snoop_valid),
    .snoop_hit   (snoop_hit),
    .acc_present (acc_present),
    .acc_full    (acc_full),
    .wr_count    (wr_count),
    .set_clear   (set_clear),
    .set_ins     (set_ins),
    .ovf_evt     (ovf_evt),
    .abort       (abort),
    .cmt_valid   (cmt_valid),
    .cmt_idx     (cmt_idx),
    .commit_done (commit_done),
    .in_tx       (in_tx),
    .bus_req     (bus_req),
    .serial_mode (serial_mode),
    .ovf_flag    (ovf_flag),
    .abort_count (abort_count),
    .commit_count(commit_count)
  );
endmodule

// File: rtl/tmcd_chk.sv
module tmcd_chk #(
  parameter int unsigned STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_valid,
  input logic              bus_grant,
  input logic              in_tx,
  input logic              bus_req,
  input logic              cmt_valid,
  input logic              commit_done,
  input logic              abort,
  input logic              serial_mode,
  input logic              ovf_flag,
  input logic [STAT_W-1:0] abort_count,
  input logic [STAT_W-1:0] commit_count
);
  // R3
  abort_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> snoop_valid);
  // R3
  abort_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (in_tx && !bus_req && !cmt_valid));
  // R4
  no_abort_issuing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> !abort);
  // R4
  no_abort_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tx |-> !abort);
  // R5
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !abort && !bus_grant) |=> bus_req);
  // R6
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (!in_tx && !serial_mode));
  // R7
  ovf_enters_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> serial_mode);
  // R8
  abort_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (abort_count == $past(abort_count) + STAT_W'(1)));
  // R8
  commit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (commit_count == $past(commit_count) + STAT_W'(1)));
endmodule

bind tmcd_tx_tracker tmcd_chk #(.STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snoop_valid (snoop_valid),
  .bus_grant   (bus_grant),
  .in_tx       (in_tx),
  .bus_req     (bus_req),
  .cmt_valid   (cmt_valid),
  .commit_done (commit_done),
  .abort       (abort),
  .serial_mode (serial_mode),
  .ovf_flag    (ovf_flag),
  .abort_count (abort_count),
  .commit_count(commit_count)
);

// File: tb/test_tmcd_tx_tracker.sv
`timescale 1ns/1ps
module test_tmcd_tx_tracker;
  localparam int ADDR_W = 16, OFF = 6, DEPTH = 4, STAT_W = 16;
  localparam int LW = ADDR_W - OFF;

  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, acc_valid = 0, acc_write = 0, commit_req = 0, bus_grant = 0, snoop_valid = 0;
  logic [ADDR_W-1:0] acc_addr = '0, snoop_addr = '0;
  logic in_tx, bus_req, cmt_valid, commit_done, abort, serial_mode, ovf_flag;
  logic [LW-1:0] cmt_line;
  logic [STAT_W-1:0] abort_count, commit_count;

  tmcd_tx_tracker #(.ADDR_W(ADDR_W), .OFF_BITS(OFF), .DEPTH(DEPTH), .STAT_W(STAT_W)) i_tmcd_tx_tracker (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 open, 2 waiting, 3 issuing, 4 serial
  int mst = 0, midx = 0, mab = 0, mcm = 0;
  bit movf = 0;
  int rq[$], wq[$];

  function automatic bit in_q(int l, bit wr);
    if (wr) begin foreach (wq[i]) if (wq[i] == l) return 1; end
    else begin foreach (rq[i]) if (rq[i] == l) return 1; end
    return 0;
  endfunction

  function automatic bit m_abort();
    int l = int'(snoop_addr) >> OFF;
    return (mst == 1 || mst == 2) && snoop_valid && (in_q(l, 0) || in_q(l, 1));
  endfunction

  function automatic bit m_done();
    return mst == 3 && (wq.size() == 0 || midx == wq.size() - 1);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ea = m_abort();
    bit ecv = (mst == 3) && (wq.size() != 0);
    chk(in_tx == (mst >= 1 && mst <= 3), "R2", "in_tx", in_tx, (mst >= 1 && mst <= 3));
    chk(bus_req == (mst == 2), "R5", "bus_req", bus_req, (mst == 2));
    chk(abort == ea, ea ? "R3" : "R4", "abort", abort, ea);
    chk(cmt_valid == ecv, "R6", "cmt_valid", cmt_valid, ecv);
    if (ecv) chk(int'(cmt_line) == wq[midx], "R6", "cmt_line", cmt_line, wq[midx]);
    chk(commit_done == m_done(), "R6", "commit_done", commit_done, m_done());
    chk(serial_mode == (mst == 4), "R7", "serial_mode", serial_mode, (mst == 4));
    chk(ovf_flag == movf, "R7", "ovf_flag", ovf_flag, movf);
    chk(abort_count == STAT_W'(mab), "R8", "abort_count", abort_count, STAT_W'(mab));
    chk(commit_count == STAT_W'(mcm), "R8", "commit_count", commit_count, STAT_W'(mcm));
  endtask

  task automatic model_update();
    if (m_abort()) begin
      mab++; rq.delete(); wq.delete(); mst = 1;
    end else begin
      case (mst)
        0: if (tx_begin) begin mst = 1; movf = 0; end
        1: begin
          if (acc_valid) begin
            int l = int'(acc_addr) >> OFF;
            if (!in_q(l, acc_write)) begin
              if ((acc_write ? wq.size() : rq.size()) == DEPTH) begin
                movf = 1; rq.delete(); wq.delete(); mst = 4;
              end else if (acc_write) wq.push_back(l);
              else rq.push_back(l);
            end
          end
          if (mst == 1 && commit_req) mst = 2;
        end
        2: if (bus_grant) begin mst = 3; midx = 0; end
        3: if (m_done()) begin mcm++; rq.delete(); wq.delete(); mst = 0; end
           else midx++;
        4: if (commit_req) begin mcm++; mst = 0; end
        default: mst = 0;
      endcase
    end
  endtask

  // one cycle: drive at the falling edge, compare, advance the model at the rising edge
  task automatic step(bit tb, bit av, bit aw, int aa, bit cr, bit bg, bit sv, int sa);
    tx_begin = tb; acc_valid = av; acc_write = aw; acc_addr = ADDR_W'(aa);
    commit_req = cr; bus_grant = bg; snoop_valid = sv; snoop_addr = ADDR_W'(sa);
    #2 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_cyc(); step(0,0,0,0,0,0,0,0); endtask
  function automatic int L(int n); return n << OFF; endfunction

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R1 reset state
    chk(!in_tx && !bus_req && !cmt_valid && !commit_done && !abort, "R1", "ctl after reset",
        {in_tx, bus_req, cmt_valid, commit_done, abort}, 0);
    chk(!serial_mode && !ovf_flag && abort_count == 0 && commit_count == 0, "R1", "status after reset",
        {serial_mode, ovf_flag, abort_count, commit_count}, 0);
    @(negedge clk);

    // R4 snoop while idle
    step(0,0,0,0,0,0,1,L(1));
    // R2 open, record, duplicate
    step(1,0,0,0,0,0,0,0);
    step(0,1,0,L(1),0,0,0,0);
    step(0,1,1,L(2)+4,0,0,0,0);
    step(0,1,0,L(1)+8,0,0,0,0);
    step(0,0,0,0,0,0,1,L(3));          // R4 unrelated line
    step(0,0,0,0,0,0,1,L(1)+33);       // R3 read-set hit, other offset
    step(0,0,0,0,0,0,1,L(1));          // R3 sets emptied: no abort now
    step(0,1,1,L(5),0,0,0,0);
    step(0,0,0,0,0,0,1,L(5)+63);       // R3 write-set hit
    // R5 wait, abort while waiting
    step(0,1,0,L(4),0,0,0,0);
    step(0,1,1,L(5),1,0,0,0);          // recorded alongside commit_req
    step(0,1,1,L(6),0,0,0,0);          // ignored while waiting
    idle_cyc();
    step(0,0,0,0,0,0,1,L(6));          // R4 line 6 was not recorded
    step(0,0,0,0,0,0,1,L(5));          // R3 abort while waiting
    // R6 issue order, snoop during issue
    step(0,1,1,L(5),0,0,0,0);
    step(0,1,1,L(6),0,0,0,0);
    step(0,1,1,L(5),0,0,0,0);
    step(0,1,1,L(7),1,0,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,1,L(5));          // R4 issuing: no abort
    step(0,0,0,0,0,0,1,L(6));
    idle_cyc();
    idle_cyc();
    // R6 empty write set
    step(1,0,0,0,0,0,0,0);
    step(0,1,0,L(2),1,0,0,0);
    step(0,0,0,0,0,1,0,0);
    idle_cyc();
    idle_cyc();
    // R7 overflow after duplicates (R2)
    step(1,0,0,0,0,0,0,0);
    for (int i = 0; i < 4; i++) step(0,1,0,L(i),0,0,0,0);
    step(0,1,0,L(0)+1,0,0,0,0);
    #2 chk(!serial_mode && in_tx, "R2", "duplicate does not fill", serial_mode, 0);
    @(negedge clk);
    step(0,1,0,L(7),0,0,0,0);
    step(0,0,0,0,0,0,1,L(0));          // R4 serial: no abort
    step(0,1,1,L(1),0,0,0,0);
    step(0,0,0,0,1,0,0,0);
    idle_cyc();
    step(1,0,0,0,0,0,0,0);             // R2 clears ovf_flag
    idle_cyc();

    // random phase, all requirements against the model
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom % 100;
      step((mst == 0) ? ($urandom % 3 == 0) : ($urandom % 20 == 0),
           ($urandom % 2 == 0), ($urandom % 2 == 0), L($urandom % 8) + ($urandom % 64),
           (r < 12), ($urandom % 3 == 0),
           ($urandom % 5 == 0), L($urandom % 8) + ($urandom % 64));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule